// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between four external interrupt pins and the priority logic of an interrupt controller. Each pin is brought into the clock domain through a synchroniser. It is then judged by its own two-bit sense mode, which selects active-high level, rising edge, falling edge or active-low level. The result is one request line per pin.

Edge events are caught in sticky latches. Software removes a latched event by writing 1 to that pin's clear bit in the control word. Every request is gated by the pin's enable bit and by a master external enable. The whole configuration sits in one 32-bit control register with a plain write strobe and a continuous read-back.

The bit positions of the control word are fixed, because the priority and CPU-side logic decode the same fields:

| Bits | Meaning |
|---|---|
| 27:24 | Write-1 clear for pins 0..3, in that order |
| 23:16 | Two-bit mode of pin n at [23-2n : 22-2n] |
| 12 | Master external enable |
| 11:8 | Enable of pins 0..3, in that order |
| 0 | Critical-routing select, forwarded to an output |

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0x00000000, every request is low, and the critical-routing output is low.
- R2: A write stores the written word. Bits 27:24 always read back as 0, and every other bit reads back as last written.
- R3: The mode of pin n is control bits [23-2n:22-2n], and the enable of pin n is control bit 11-n.
- R4: In mode 0 (active-high level) the request of an enabled pin follows the pin, delayed by the two-flop synchroniser, and it is not latched.
- R5: In mode 3 (active-low level) the request of an enabled pin follows the inverted pin and is not latched.
- R6: In mode 1 a rising edge on the pin sets that pin's latch, and the request appears three clock edges after the pin changes. The request stays high after the pin returns low.
- R7: In mode 2 a falling edge sets the latch. A rising edge does not set it.
- R8: Writing 1 to control bit 27-n clears the latch of pin n. A write that leaves that bit 0 does not disturb the latch.
- R9: When an edge is detected in the same cycle as a write-1 clear, the latch stays set.
- R10: The latch records edges while the pin is disabled. Setting the enable bit later raises the request.
- R11: While control bit 12 is 0, every request is low. Latched events survive and reappear when the bit is set again.
- R12: The critical-routing output equals control bit 0.
- R13: A pin in a level mode (0 or 3) holds no latched event, so an edge caught earlier is dropped when the pin is moved to a level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read-back |
| req_o | output | 4 | Conditioned request per pin |
| crit_route_o | output | 1 | Critical-routing select (control bit 0) |

## Verification
Two things can hit the same latch in the same clock: a detected edge and a software write-1 clear. The bench raises the pin and then times the clear write so that it lands on the clock edge where the synchronised edge is seen. It judges the result from the request output: the request must stay high afterwards. A clear issued in any other cycle must drop the request, which confirms that the surviving request comes from the collision rule and not from a clear that does nothing.

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  pin_i,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [3:0]  req_o,
  output logic        crit_route_o
);
  localparam int NPIN     = 4;
  localparam int DW       = 32;
  localparam int MEE_BIT  = 12;
  localparam int CRIT_BIT = 0;
  localparam logic [DW-1:0] CLR_MASK = 32'h0F00_0000;

  logic [DW-1:0]   ctrl_q;
  logic [NPIN-1:0] pin_s, pin_d, latch_q, edge_hit, clr_hit, en, is_edge, lvl_act;
  logic            mee;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & ~CLR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_d <= '0;
    else        pin_d <= pin_s;
  end

  assign rd_data      = ctrl_q;
  assign mee          = ctrl_q[MEE_BIT];
  assign crit_route_o = ctrl_q[CRIT_BIT];

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic [SYNC_STAGES-1:0] sh;
    logic [1:0]             mode;

    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-2:0], pin_i[n]};
    end

    assign pin_s[n]    = sh[SYNC_STAGES-1];
    assign mode        = ctrl_q[23-2*n -: 2];
    assign en[n]       = ctrl_q[11-n];
    assign is_edge[n]  = (mode == 2'd1) || (mode == 2'd2);
    assign edge_hit[n] = (mode == 2'd1) ? (pin_s[n] & ~pin_d[n]) :
                         (mode == 2'd2) ? (~pin_s[n] & pin_d[n]) : 1'b0;
    assign clr_hit[n]  = wr_en & wr_data[27-n];
    assign lvl_act[n]  = (mode == 2'd3) ? ~pin_s[n] : pin_s[n];

    always_ff @(posedge clk) begin
      if (!rst_n)           latch_q[n] <= 1'b0;
      else if (!is_edge[n]) latch_q[n] <= 1'b0;
      else if (edge_hit[n]) latch_q[n] <= 1'b1;
      else if (clr_hit[n])  latch_q[n] <= 1'b0;
    end

    assign req_o[n] = mee & en[n] & (is_edge[n] ? latch_q[n] : lvl_act[n]);

    a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[n] |=> latch_q[n]);
    a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit[n] && clr_hit[n]) |=> latch_q[n]);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[n] && !edge_hit[n]) |=> !latch_q[n]);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q[n] && !clr_hit[n] && is_edge[n]) |=> latch_q[n]);
    a_r13_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !is_edge[n] |=> !latch_q[n]);
  end

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & ~CLR_MASK));
  a_r2_clear_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & CLR_MASK) == '0);
  a_r11_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[MEE_BIT] |-> req_o == '0);
endmodule

// File: tb/ext_irq_cond_test.sv
module ext_irq_cond_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_i = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  req_o;
  logic        crit_route_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] CLR = 32'h0F00_0000;

  ext_irq_cond uut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .req_o(req_o), .crit_route_o(crit_route_o));

  always #10 clk = ~clk;

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(int n, int m, bit mee, bit en, bit clr_all);
    logic [31:0] w = '0;
    w[12] = mee;
    w[11-n] = en;
    w[23-2*n -: 2] = m[1:0];
    if (clr_all) w[27:24] = 4'hF;
    return w;
  endfunction

  function automatic logic [31:0] xreq(int n, int m, bit p, bit lat);
    bit b = (m == 0) ? p : (m == 3) ? !p : lat;
    return 32'(b) << n;
  endfunction

  function automatic string mtag(int m);
    return (m == 0) ? "R4" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R5";
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 ctrl", rd_data, 32'h0);
    chk("R1 req", 32'(req_o), 32'h0);
    chk("R1 crit", 32'(crit_route_o), 32'h0);

    wr(32'hFFFF_FFFF);
    chk("R2 all ones", rd_data, 32'hF0FF_FFFF);
    wr(32'hA5A5_A5A5);
    chk("R2 pattern", rd_data, 32'hA0A5_A5A5);
    wr(32'h0);

    for (int n = 0; n < 4; n++) begin
      for (int m = 0; m < 4; m++) begin
        bit lat = 1'b0;
        pin_i = '0;
        tick(4);
        wr(cw(n, m, 1, 1, 1));
        chk("R3 readback", rd_data, cw(n, m, 1, 1, 1) & ~CLR);
        chk({mtag(m), " idle"}, 32'(req_o), xreq(n, m, 0, lat));
        pin_i[n] = 1'b1;
        tick(3);
        if (m == 1) lat = 1'b1;
        chk({mtag(m), " high"}, 32'(req_o), xreq(n, m, 1, lat));
        pin_i[n] = 1'b0;
        tick(3);
        if (m == 2) lat = 1'b1;
        chk({mtag(m), " low"}, 32'(req_o), xreq(n, m, 0, lat));
        wr(cw(n, m, 1, 1, 0));
        chk("R8 zero write keeps", 32'(req_o), xreq(n, m, 0, lat));
        wr(cw(n, m, 1, 1, 0) | (32'h1 << (27 - n)));
        lat = 1'b0;
        chk("R8 clear", 32'(req_o), xreq(n, m, 0, lat));
      end
    end

    wr(cw(0, 1, 1, 0, 1));
    pin_i[0] = 1'b1;
    tick(3);
    chk("R10 disabled", 32'(req_o), 32'h0);
    wr(cw(0, 1, 1, 1, 0));
    chk("R10 enabled later", 32'(req_o), 32'h1);
    pin_i[0] = 1'b0;
    tick(3);

    wr(cw(0, 1, 0, 1, 0));
    chk("R11 master off", 32'(req_o), 32'h0);
    wr(cw(0, 1, 1, 1, 0));
    chk("R11 master back", 32'(req_o), 32'h1);

    wr(cw(0, 0, 1, 1, 0));
    chk("R13 level mode", 32'(req_o), 32'h0);
    wr(cw(0, 1, 1, 1, 0));
    chk("R13 latch dropped", 32'(req_o), 32'h0);

    wr(cw(0, 1, 1, 1, 1));
    pin_i[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr(cw(0, 1, 1, 1, 0) | 32'h0800_0000);
    chk("R9 edge with clear", 32'(req_o), 32'h1);
    wr(cw(0, 1, 1, 1, 0) | 32'h0800_0000);
    chk("R9 later clear", 32'(req_o), 32'h0);
    pin_i[0] = 1'b0;
    tick(3);

    wr(32'h1);
    chk("R12 crit set", 32'(crit_route_o), 32'h1);
    wr(32'h0);
    chk("R12 crit clear", 32'(crit_route_o), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule